// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Per-Operation Flag Rules

This block is the arithmetic and logic stage of an eight-bit accumulator datapath. Each transaction carries an operation code, an accumulator operand A, a second operand B and the current flag byte. The block returns an eight-bit result and a new flag byte. Each operation class writes its own subset of the six architected flags and leaves the others as they came in. The parity/overflow bit holds two's-complement overflow for arithmetic and even parity for the bitwise operations.

The stage is one register deep and sits on a valid/ready stream. A transaction is taken on a rising clock edge where `in_valid` and `in_ready` are both high. Its result shows on the output one cycle later and stays there until it is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so it depends combinationally on `out_ready`. Back-pressure from the consumer therefore stalls the producer with no bubble and no loss. The producer must hold its inputs steady while `in_valid` is high and `in_ready` is low.

Flag byte layout, used for both the incoming and outgoing flags: bit 7 sign (S), bit 6 zero (Z), bit 4 half carry (H), bit 2 parity/overflow (PV), bit 1 subtract (N), bit 0 carry (C). Bits 5 and 3 are spare.

Top module: `zflag_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high after that same edge. `in_ready` equals `!out_valid || out_ready`.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_flags` keep their values into the next cycle.
- R3: Op 0 (add) gives A+B, and op 1 (add with carry) gives A+B+C_in. S is result bit 7 and Z is set when the result is zero. H is the carry out of bit 3 and PV is signed overflow, which occurs when A and B share a sign that the result lacks. C is the carry out of bit 7, and N is 0.
- R4: Op 2 (subtract) gives A−B, and op 3 (subtract with carry) gives A−B−C_in. S and Z are taken from the result. H is the borrow into bit 4 and PV is signed overflow, which occurs when A and B differ in sign and the result sign differs from A. C is the borrow out of bit 7, and N is 1.
- R5: Op 4 (compare) sets the flags as op 2 would for A−B, but `out_result` equals A.
- R6: Op 5 (AND) gives A&B, with S and Z from the result and PV = 1 when the result has an even number of ones. H is 1, and N and C are 0.
- R7: Op 6 (OR) and op 7 (XOR) give A|B and A^B, with S, Z and even parity in PV from the result. H, N and C are all 0.
- R8: Op 8 (increment) gives A+1 and op 9 (decrement) gives A−1. S, Z, H and PV follow the rules of R3 and R4 with B = 1. N is 0 for op 8 and 1 for op 9. C keeps its incoming value.
- R9: Op 10 (complement) gives ~A and sets H and N to 1. S, Z, PV and C keep their incoming values.
- R10: Op 11 (set carry) gives result A with C = 1, H = 0 and N = 0. Op 12 (complement carry) gives result A with C = !C_in, H = C_in and N = 0. Both keep S, Z and PV unchanged.
- R11: Ops 13 to 15 return A and leave the flag byte unchanged. For every op, flag bits 5 and 3 are copied from the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Stage can take a transaction this cycle |
| in_op | input | 4 | Operation code (see R3 to R11) |
| in_a | input | 8 | Accumulator operand |
| in_b | input | 8 | Second operand |
| in_flags | input | 8 | Incoming flag byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Operation result |
| out_flags | output | 8 | New flag byte |

## Verification
The assertions check on every cycle that a stalled result stays put and that an accepted transaction lands in the output register. They also cover the flag rules that can be tied directly from an input to the registered output: compare returns A and sets N, increment and decrement keep C, AND forces H and clears C, add sets Z exactly when the result is zero, and the spare bits pass through. Only the bench's scenarios can show the full arithmetic. That covers half-carry and overflow at the 0x7F/0x80 and nibble boundaries, carry and borrow chained from C_in, parity on the bitwise results, the carry-flag operations, and the spare opcodes. The same scenarios show that result order and content survive random back-pressure.

// File: rtl/zalu_pkg.sv
`timescale 1ns/1ps
package zalu_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  // Flag byte bit positions
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_X5 = 5;
  localparam int FB_H  = 4;
  localparam int FB_X3 = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CP  = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CPL = 4'd10,
    OP_SCF = 4'd11,
    OP_CCF = 4'd12,
    OP_R13 = 4'd13,
    OP_R14 = 4'd14,
    OP_R15 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/zalu_arith.sv
`timescale 1ns/1ps
// Shared add/subtract path. Subtraction runs as A + ~B + !cin; carry and
// half carry are inverted back into borrows at the output.
module zalu_arith #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         half,
  output logic         ovf,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic         c_top;

  always_comb begin
    b_eff = sub ? ~b : b;
    c0    = sub ? ~cin : cin;
    {c_top, res} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    // carry into bit HB recovered from the sum bit
    half  = a[HB] ^ b_eff[HB] ^ res[HB] ^ sub;
    cout  = c_top ^ sub;
    ovf   = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
  end
endmodule

// File: rtl/zalu_logic.sv
`timescale 1ns/1ps
// Bitwise operations with even-parity indication.
module zalu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,   // 0: and, 1: or, 2/3: xor
  output logic [W-1:0] res,
  output logic         par_even
);
  always_comb begin
    unique case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      default: res = a ^ b;
    endcase
    par_even = ~(^res);
  end
endmodule

// File: rtl/zalu_core.sv
`timescale 1ns/1ps
// Combinational operation select and per-class flag rules.
module zalu_core
  import zalu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [7:0]        fin,
  output logic [DATA_W-1:0] res,
  output logic [7:0]        fout
);
  alu_op_e op_e;
  logic [DATA_W-1:0] ar_b, ar_res, lg_res;
  logic ar_cin, ar_sub, ar_half, ar_ovf, ar_cout, lg_par;
  logic [1:0] lg_sel;
  logic fs, fz, fh, fpv, fn, fc;

  assign op_e = alu_op_e'(op);

  always_comb begin
    ar_b   = b;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    unique case (op_e)
      OP_ADC: ar_cin = fin[FB_C];
      OP_SUB, OP_CP: ar_sub = 1'b1;
      OP_SBC: begin ar_sub = 1'b1; ar_cin = fin[FB_C]; end
      OP_INC: ar_b = DATA_W'(1);
      OP_DEC: begin ar_b = DATA_W'(1); ar_sub = 1'b1; end
      default: ;
    endcase
    unique case (op_e)
      OP_AND:  lg_sel = 2'd0;
      OP_OR:   lg_sel = 2'd1;
      default: lg_sel = 2'd2;
    endcase
  end

  zalu_arith #(.W(DATA_W), .HB(4)) u_arith (
    .a(a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .res(ar_res), .half(ar_half), .ovf(ar_ovf), .cout(ar_cout)
  );

  zalu_logic #(.W(DATA_W)) u_logic (
    .a(a), .b(b), .sel(lg_sel), .res(lg_res), .par_even(lg_par)
  );

  always_comb begin
    res = a;
    fs  = fin[FB_S];
    fz  = fin[FB_Z];
    fh  = fin[FB_H];
    fpv = fin[FB_PV];
    fn  = fin[FB_N];
    fc  = fin[FB_C];
    unique case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res = ar_res;
        fs  = ar_res[DATA_W-1];
        fz  = (ar_res == '0);
        fh  = ar_half;
        fpv = ar_ovf;
        fn  = ar_sub;
        fc  = ar_cout;
      end
      OP_CP: begin
        fs  = ar_res[DATA_W-1];
        fz  = (ar_res == '0);
        fh  = ar_half;
        fpv = ar_ovf;
        fn  = 1'b1;
        fc  = ar_cout;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = lg_res;
        fs  = lg_res[DATA_W-1];
        fz  = (lg_res == '0);
        fh  = (op_e == OP_AND);
        fpv = lg_par;
        fn  = 1'b0;
        fc  = 1'b0;
      end
      OP_INC, OP_DEC: begin
        res = ar_res;
        fs  = ar_res[DATA_W-1];
        fz  = (ar_res == '0);
        fh  = ar_half;
        fpv = ar_ovf;
        fn  = ar_sub;
      end
      OP_CPL: begin
        res = ~a;
        fh  = 1'b1;
        fn  = 1'b1;
      end
      OP_SCF: begin
        fh = 1'b0;
        fn = 1'b0;
        fc = 1'b1;
      end
      OP_CCF: begin
        fh = fin[FB_C];
        fn = 1'b0;
        fc = ~fin[FB_C];
      end
      default: ;
    endcase
    fout = {fs, fz, fin[FB_X5], fh, fin[FB_X3], fpv, fn, fc};
  end
endmodule

// File: rtl/zflag_alu.sv
`timescale 1ns/1ps
// Stream wrapper: one output register with valid/ready on both sides.
module zflag_alu
  import zalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [7:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [7:0]        out_flags
);
  logic [DATA_W-1:0] core_res;
  logic [7:0]        core_flags;
  logic              take;

  zalu_core u_core (
    .op(in_op), .a(in_a), .b(in_b), .fin(in_flags),
    .res(core_res), .fout(core_flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= core_res;
        out_flags  <= core_flags;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zflag_alu_chk.sv
`timescale 1ns/1ps
module zflag_alu_chk
  import zalu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [7:0]        in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [7:0]        out_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_flags)));

  a_r3_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADD) |=> (out_flags[FB_Z] == (out_result == '0)));

  a_r5_cp_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_CP) |=> (out_result == $past(in_a) && out_flags[FB_N]));

  a_r6_and_hc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_AND) |=>
      (out_flags[FB_H] && !out_flags[FB_C] && !out_flags[FB_N]));

  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_INC || in_op == OP_DEC)) |=>
      (out_flags[FB_C] == $past(in_flags[FB_C])));

  a_r11_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_flags[FB_X5] == $past(in_flags[FB_X5]) &&
             out_flags[FB_X3] == $past(in_flags[FB_X3])));
endmodule

bind zflag_alu zflag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/zflag_alu_tb.sv
`timescale 1ns/100ps
module zflag_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0, in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result, out_flags;

  int n_chk = 0;
  int n_fail = 0;
  logic [19:0] sb_q[$];   // {op, result, flags}
  bit   stall_mode = 0;
  logic [15:0] rdy_lfsr = 16'hACE1;
  bit   done = 0;

  always #2 clk = ~clk;

  zflag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4:       return "R5";
      5:       return "R6";
      6, 7:    return "R7";
      8, 9:    return "R8";
      10:      return "R9";
      11, 12:  return "R10";
      default: return "R11";
    endcase
  endfunction

  // Reference model written from the requirements with integer arithmetic.
  function automatic logic [15:0] ref_alu(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
    int ci, s, sa, sb, ss, lo;
    logic [7:0] r;
    logic S, Z, H, P, N, C;
    ci = int'(f[0]);
    r = a; S = f[7]; Z = f[6]; H = f[4]; P = f[2]; N = f[1]; C = f[0];
    sa = int'($signed(a)); sb = int'($signed(b));
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        s = int'(a) + int'(b) + ci; lo = int'(a[3:0]) + int'(b[3:0]) + ci;
        ss = sa + sb + ci; r = s[7:0];
        H = lo > 15; C = s > 255; P = (ss > 127) || (ss < -128); N = 0;
        S = r[7]; Z = (r == 0);
      end
      2, 3, 4: begin
        if (op != 3) ci = 0;
        s = int'(a) - int'(b) - ci; lo = int'(a[3:0]) - int'(b[3:0]) - ci;
        ss = sa - sb - ci;
        H = lo < 0; C = s < 0; P = (ss > 127) || (ss < -128); N = 1;
        S = s[7]; Z = (s[7:0] == 0);
        r = (op == 4) ? a : s[7:0];
      end
      5, 6, 7: begin
        r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
        S = r[7]; Z = (r == 0); P = ($countones(r) % 2) == 0;
        H = (op == 5); N = 0; C = 0;
      end
      8, 9: begin
        s = (op == 8) ? int'(a) + 1 : int'(a) - 1; r = s[7:0];
        H = (op == 8) ? (a[3:0] == 4'hF) : (a[3:0] == 4'h0);
        P = (op == 8) ? (a == 8'h7F) : (a == 8'h80);
        N = (op == 9); S = r[7]; Z = (r == 0);
      end
      10: begin r = ~a; H = 1; N = 1; end
      11: begin C = 1; H = 0; N = 0; end
      12: begin H = f[0]; C = ~f[0]; N = 0; end
      default: ;
    endcase
    return {r, S, Z, f[5], H, f[3], P, N, C};
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: presents one item, pushes its expectation when the transfer is seen.
  task automatic send(input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] f);
    @(negedge clk);
    in_valid = 1; in_op = op; in_a = a; in_b = b; in_flags = f;
    forever begin
      #0.2;
      check("R1", in_ready == (!out_valid || out_ready), in_ready, !out_valid || out_ready);
      if (in_ready) begin
        sb_q.push_back({op, ref_alu(op, a, b, f)});
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // Consumer pacing
  always @(negedge clk) begin
    rdy_lfsr <= {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
    out_ready = stall_mode ? rdy_lfsr[3] : 1'b1;
  end

  // Monitor / scoreboard
  bit held_v = 0;
  logic [15:0] held;
  always @(negedge clk) begin
    #0.4;
    if (rst_n) begin
      if (held_v)
        check("R2", out_valid && {out_result, out_flags} == held,
              {out_valid, out_result, out_flags}, {1'b1, held});
      held_v = out_valid && !out_ready;
      held = {out_result, out_flags};
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check("R1", 0, 1, 0);
        end else begin
          logic [19:0] e;
          e = sb_q.pop_front();
          check(req_of(e[19:16]), {out_result, out_flags} == e[15:0],
                {out_result, out_flags}, e[15:0]);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #0.4;
    check("R1", out_valid == 0, out_valid, 0);   // R1 reset state
    check("R1", in_ready == 1, in_ready, 1);

    // R3 add corners
    send(0, 8'h7F, 8'h01, 8'h00);
    send(0, 8'hFF, 8'h01, 8'h00);
    send(0, 8'h00, 8'h00, 8'hFF);
    send(1, 8'h0F, 8'h00, 8'h01);
    send(1, 8'h80, 8'h7F, 8'h01);
    // R4 subtract corners
    send(2, 8'h80, 8'h01, 8'h00);
    send(2, 8'h00, 8'h01, 8'h00);
    send(2, 8'h10, 8'h01, 8'h01);
    send(3, 8'h05, 8'h05, 8'h01);
    send(3, 8'h7F, 8'hFF, 8'h01);
    // R5 compare
    send(4, 8'h55, 8'h55, 8'h00);
    send(4, 8'h03, 8'h90, 8'h28);
    // R6 / R7 bitwise with parity
    send(5, 8'hF0, 8'h3C, 8'h01);
    send(5, 8'h0F, 8'hF0, 8'h13);
    send(6, 8'h81, 8'h02, 8'h01);
    send(7, 8'hA5, 8'hA5, 8'h11);
    // R8 inc/dec keep C
    send(8, 8'hFF, 8'h00, 8'h01);
    send(8, 8'h7F, 8'h00, 8'h00);
    send(9, 8'h80, 8'h00, 8'h01);
    send(9, 8'h00, 8'h00, 8'h00);
    // R9 complement
    send(10, 8'h3C, 8'h00, 8'hC5);
    // R10 carry ops
    send(11, 8'h12, 8'h00, 8'hD6);
    send(12, 8'h12, 8'h00, 8'h01);
    send(12, 8'h12, 8'h00, 8'hC4);
    // R11 spare codes and bits
    send(13, 8'h9A, 8'h11, 8'hAB);
    send(15, 8'h01, 8'h22, 8'h28);

    // Mixed traffic, then with random back-pressure (R2)
    lf = 16'h1D2C;
    for (int i = 0; i < 400; i++) begin
      if (i == 200) stall_mode = 1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[3:0], lf[15:8] ^ 8'(i), lf[7:0] + 8'(i * 3), {lf[11:4]});
    end
    stall_mode = 0;
    repeat (20) @(posedge clk);
    check("R1", sb_q.size() == 0, sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule